// File: doc/BRIEF.md
# Ten-Stage Counter with Qualified Terminal Status

This block is a 10-bit up counter built as a chain of toggle stages. Each stage flips when every stage below it holds a one, so the chain counts in binary, and the count rolls from its all-ones value back to zero. Two clear paths reset the chain. The first clear acts at once, without waiting for a clock edge. The second is a clock-aligned request that is taken only at a rising edge.

Beside the count, the block drives one active-low status flag. The flag is built from two equality decoders. One fires at count 2. The other fires at the all-ones count, 1023. Each decoder has its own qualifying inputs, and two enable inputs gate the flag as well. The flag is combinational: it follows the count and the condition inputs without any register. Downstream logic reads the raw count bits and the flag.

Top module: `tick_chain_status`

## Requirements
- R1: While `clr_async` is 1, `count` is 0. The clear takes effect without any clock edge.
- R2: On each rising edge of `clk` where neither clear is active, `count` increases by exactly one.
- R3: When `clr_sync` is 1 at a rising edge, `count` becomes 0 after that edge. Before the edge, the request leaves `count` unchanged.
- R4: From count 1023 (all ten bits 1), the next counting edge gives count 0.
- R5: `clr_async` takes priority over `clr_sync`, and both take priority over counting. While `clr_async` is held, edges leave `count` at 0. The first counting edge after release gives count 1.
- R6: `status_n` is 0 whenever `en_a` or `en_b` is 0.
- R7: When `count` equals 2 and `mask_low` is 0, `status_n` is 0. A 1 on `mask_low` suppresses this decode.
- R8: When `count` equals 1023, `mask_high` is 0 and `arm_high` is 1, `status_n` is 0. Any other setting of those two inputs suppresses this decode.
- R9: Outside the cases in R6 to R8, `status_n` is 1. The flag responds to changes on the condition inputs within the same clock cycle, with no clock edge needed.
- R10: All ten count bits appear on `count`, with bit 9 as the MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| clr_async | input | 1 | Immediate clear, active high |
| clr_sync | input | 1 | Clear request taken at a rising edge, active high |
| en_a | input | 1 | Flag enable A; 0 forces the flag active |
| en_b | input | 1 | Flag enable B; 0 forces the flag active |
| mask_low | input | 1 | 1 suppresses the count-2 decode |
| mask_high | input | 1 | 1 suppresses the all-ones decode |
| arm_high | input | 1 | 1 allows the all-ones decode |
| count | output | 10 | Current count |
| status_n | output | 1 | Active-low status flag |

## Verification
The bench walks the counter through more than one full cycle of its range. At every count value it applies all 32 settings of the condition inputs.
- A swapped or mis-decoded match value would drive the flag low at the wrong count, or fail to drive it low at the right one.
- A qualifier with the wrong polarity, for example an all-ones decode that ignores `arm_high`, fails at count 1023 or at count 2.
- A wrong carry in the toggle chain shows up as a broken wrap from 1023 to 0, or as a skipped count.

The bench also covers the two clear paths:
- A clear that waits for an edge fails the check made right after `clr_async` rises.
- A clock-aligned clear that acts at once fails the check made before the edge.
- Reversed priority lets the count move while `clr_async` is held.

// File: rtl/tick_chain_status.sv
module tick_chain_status #(
  parameter int WIDTH     = 10,
  parameter int LOW_MATCH = 2
) (
  input  logic             clk,
  input  logic             clr_async,
  input  logic             clr_sync,
  input  logic             en_a,
  input  logic             en_b,
  input  logic             mask_low,
  input  logic             mask_high,
  input  logic             arm_high,
  output logic [WIDTH-1:0] count,
  output logic             status_n
);

  localparam logic [WIDTH-1:0] LOW_VAL  = WIDTH'(LOW_MATCH);
  localparam logic [WIDTH-1:0] HIGH_VAL = {WIDTH{1'b1}};

  logic [WIDTH:0] carry;
  assign carry[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic q;
    assign carry[i+1] = carry[i] & q;
    always_ff @(posedge clk or posedge clr_async) begin
      if (clr_async)     q <= 1'b0;
      else if (clr_sync) q <= 1'b0;
      else if (carry[i]) q <= ~q;
    end
    assign count[i] = q;
  end

  logic hit_low, hit_high;
  assign hit_low  = (count == LOW_VAL)  & ~mask_low;
  assign hit_high = (count == HIGH_VAL) & ~mask_high & arm_high;
  assign status_n = en_a & en_b & ~hit_low & ~hit_high;

  AST_ASYNC_HOLD: assert property (@(posedge clk)
    clr_async |-> count == '0); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (clr_async)
    !clr_sync |=> count == WIDTH'($past(count) + 1'b1)); // R2
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (clr_async)
    clr_sync |=> count == '0); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (clr_async)
    (count == HIGH_VAL && !clr_sync) |=> count == '0); // R4
  AST_ENABLE_LOW: assert property (@(posedge clk) disable iff (clr_async)
    (!en_a || !en_b) |-> !status_n); // R6
  AST_LOW_DECODE: assert property (@(posedge clk) disable iff (clr_async)
    (count == LOW_VAL && !mask_low) |-> !status_n); // R7
  AST_HIGH_DECODE: assert property (@(posedge clk) disable iff (clr_async)
    (count == HIGH_VAL && !mask_high && arm_high) |-> !status_n); // R8
  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (clr_async)
    (en_a && en_b && count != LOW_VAL && count != HIGH_VAL) |-> status_n); // R9

endmodule

// File: tb/test_tick_chain_status.sv
module test_tick_chain_status;
  localparam int CLK_PERIOD = 100;

  logic clk = 1'b0;
  logic clr_async = 1'b1, clr_sync = 1'b0;
  logic en_a = 1'b1, en_b = 1'b1, mask_low = 1'b0, mask_high = 1'b0, arm_high = 1'b0;
  logic [9:0] count;
  logic status_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  tick_chain_status i_tick_chain_status (
    .clk(clk), .clr_async(clr_async), .clr_sync(clr_sync),
    .en_a(en_a), .en_b(en_b), .mask_low(mask_low), .mask_high(mask_high),
    .arm_high(arm_high), .count(count), .status_n(status_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int exp_cnt;
    #(CLK_PERIOD/4);
    chk("R1 count under async clear at start", count, 0);
    clr_sync = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5 async clear holds over edges and sync request", count, 0);
    clr_sync = 1'b0;
    clr_async = 1'b0;
    exp_cnt = 0;
    for (int n = 0; n < 1100; n++) begin
      chk("R2/R4/R10 count value", count, exp_cnt % 1024);
      for (int c = 0; c < 32; c++) begin
        int cv, e;
        {en_a, en_b, mask_low, mask_high, arm_high} = 5'(c);
        #1;
        cv = exp_cnt % 1024;
        e = (en_a && en_b && !(cv == 2 && !mask_low) &&
             !(cv == 1023 && !mask_high && arm_high)) ? 1 : 0;
        if (!en_a || !en_b)  chk("R6 enables force flag", status_n, e);
        else if (cv == 2)    chk("R7 count-2 decode", status_n, e);
        else if (cv == 1023) chk("R8 all-ones decode", status_n, e);
        else                 chk("R9 idle flag", status_n, e);
      end
      {en_a, en_b, mask_low, mask_high, arm_high} = 5'b11000;
      @(negedge clk);
      exp_cnt++;
    end
    exp_cnt = exp_cnt % 1024;
    clr_sync = 1'b1;
    #5;
    chk("R3 sync request waits for edge", count, exp_cnt);
    @(negedge clk);
    chk("R3 sync clear at edge", count, 0);
    clr_sync = 1'b0;
    @(negedge clk);
    chk("R2 count resumes after sync clear", count, 1);
    @(negedge clk); @(negedge clk);
    chk("R2 count before async clear", count, 3);
    #5;
    clr_async = 1'b1;
    #1;
    chk("R1 async clear acts without edge", count, 0);
    @(negedge clk);
    chk("R5 count held under async clear", count, 0);
    clr_async = 1'b0;
    @(negedge clk);
    chk("R5 first edge after release", count, 1);
    done = 1'b1;
    finish_run();
  end
endmodule